// File: doc/BRIEF.md
# Atomic trace selection unit

This unit cuts a stream of retired, decoded micro-ops into atomic traces using fixed rules, so the same input stream always gives the same trace boundaries. Each incoming micro-op carries its address, a flag that marks the last micro-op of its basic block, and a control-transfer kind. For the block-ending micro-op it also carries a taken flag and a target address. Each time a trace closes, the unit emits one descriptor. The descriptor holds the address of the trace's first micro-op, the number of micro-ops, the number of basic blocks, a 3-bit code giving why the trace closed, and a flag that marks a trace that must not be optimized.

A trace is built only from whole basic blocks and holds at most `CAP` micro-ops (default 64). A trace is closed by an indirect jump, a software exception or a backward taken branch. Calls and returns do not close a trace, so called procedures are inlined into the trace around them. If the block now being received cannot fit in the open trace, the open trace is emitted as soon as that becomes certain, and the block starts the next trace. A block longer than `CAP` becomes a trace of its own and is marked unoptimizable. A flush input drops the partly built trace.

Both streams use valid/ready. A micro-op is taken on a clock edge where `in_valid` and `in_ready` are both high. A descriptor is taken where `out_valid` and `out_ready` are both high. `in_ready` is low whenever the descriptor register is full and not being drained, so back-pressure on the output stalls the input. While `out_ready` is low, a descriptor stays on the output unchanged.

Top module: `trace_selector`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, and the first accepted micro-op starts a new trace.
- R2: Each descriptor reports the address of the trace's first micro-op, its micro-op count and its basic-block count. Every block is counted whole in exactly one trace. The descriptor is packed in this field order: start, uops, bbs, reason, noopt.
- R3: A block-ending micro-op with control-transfer kind 2 (indirect jump) closes the trace after that block with reason code 1.
- R4: A block-ending micro-op with kind 5 (software exception) closes the trace with reason code 2.
- R5: A block-ending micro-op with kind 1 (branch) closes the trace with reason code 3 when it is taken and its target is less than or equal to its own address. A not-taken branch, or a taken branch with a higher target, does not close the trace.
- R6: Kind 3 (call), kind 4 (return) and kind 0 (none) never close a trace.
- R7: A normal trace holds between 1 and `CAP` micro-ops. If a block cannot fit, the open trace is emitted with reason code 0 and the block starts the next trace. A trace that reaches exactly `CAP` micro-ops at a block end closes with reason 0, unless that block's transfer gives another reason.
- R8: A single block longer than `CAP` is emitted alone with reason 0, a block count of 1 and `out_noopt` high. Its micro-op count saturates at 2^`CNT_W`-1. `out_noopt` is low on every other descriptor.
- R9: While `flush` is high, `in_ready` is low and the partly built trace is dropped without a descriptor. The next micro-op starts a fresh trace. Reason code 4 is reserved and is never emitted.
- R10: While `out_valid` is high and `out_ready` is low, the descriptor is held stable and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop the trace under construction |
| in_valid | input | 1 | Micro-op present |
| in_ready | output | 1 | Micro-op accepted this cycle if valid |
| in_addr | input | AW | Micro-op address |
| in_bb_end | input | 1 | Last micro-op of its basic block |
| in_cti | input | 3 | Transfer kind: 0 none, 1 branch, 2 indirect, 3 call, 4 return, 5 exception |
| in_taken | input | 1 | Branch taken (block end only) |
| in_target | input | AW | Branch target (block end only) |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_start | output | AW | First micro-op address of the trace |
| out_uops | output | CNT_W | Micro-op count |
| out_bbs | output | CNT_W | Basic-block count |
| out_reason | output | 3 | 0 capacity, 1 indirect, 2 exception, 3 backward branch |
| out_noopt | output | 1 | Oversized block, do not optimize |

## Verification
The assertions assume a well-formed input stream. Every basic block ends with a micro-op that has `in_bb_end` set, the transfer kind matters only on that micro-op, and the inputs are held steady while `in_valid` waits for `in_ready`. The bench meets these assumptions by building its stimulus as whole blocks. Only the last micro-op of a block carries a transfer kind, a flush is raised only between accepted micro-ops, and a block cut short by a flush is dropped without its closing micro-op. The checks sweep block lengths against every transfer kind and both branch directions, including a target equal to the branch's own address. The bench runs with a small capacity, so that splits, exact fills and oversized blocks all occur often.

// File: rtl/trace_sel_pkg.sv
package trace_sel_pkg;

  typedef enum logic [2:0] {
    CTI_NONE      = 3'd0,
    CTI_BRANCH    = 3'd1,
    CTI_INDIRECT  = 3'd2,
    CTI_CALL      = 3'd3,
    CTI_RETURN    = 3'd4,
    CTI_EXCEPTION = 3'd5
  } cti_e;

  typedef enum logic [2:0] {
    END_CAPACITY  = 3'd0,
    END_INDIRECT  = 3'd1,
    END_EXCEPTION = 3'd2,
    END_BACKWARD  = 3'd3,
    END_FLUSH     = 3'd4
  } end_reason_e;

endpackage

// File: rtl/ts_classify.sv
module ts_classify
  import trace_sel_pkg::*;
#(
  parameter int AW = 32
) (
  input  cti_e            cti,
  input  logic            taken,
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   target,
  output logic            term,
  output end_reason_e     term_rsn
);

  always_comb begin
    term     = 1'b0;
    term_rsn = END_CAPACITY;
    unique case (cti)
      CTI_INDIRECT: begin
        term     = 1'b1;
        term_rsn = END_INDIRECT;
      end
      CTI_EXCEPTION: begin
        term     = 1'b1;
        term_rsn = END_EXCEPTION;
      end
      CTI_BRANCH: begin
        if (taken && (target <= addr)) begin
          term     = 1'b1;
          term_rsn = END_BACKWARD;
        end
      end
      default: begin
        term     = 1'b0;
        term_rsn = END_CAPACITY;
      end
    endcase
  end

endmodule

// File: rtl/ts_accum.sv
module ts_accum
  import trace_sel_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CAP   = 64,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic [AW-1:0]     addr,
  input  logic              bb_end,
  input  logic              term,
  input  end_reason_e       term_rsn,
  output logic              emit,
  output logic [AW-1:0]     e_start,
  output logic [CNT_W-1:0]  e_uops,
  output logic [CNT_W-1:0]  e_bbs,
  output end_reason_e       e_rsn,
  output logic              e_noopt
);

  localparam logic [CNT_W:0]   CAP_X   = (CNT_W + 1)'(CAP);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // closed blocks in the open trace, micro-ops of the open block
  logic [CNT_W-1:0] done_cnt, done_nx;
  logic [CNT_W-1:0] blk_cnt,  blk_nx;
  logic [CNT_W-1:0] bb_cnt,   bb_nx;
  logic [AW-1:0]    trace_pc, trace_pc_nx;
  logic [AW-1:0]    blk_pc,   blk_pc_nx;

  logic [CNT_W-1:0] blk_inc;
  logic [CNT_W:0]   sum;
  logic             fresh;
  logic [AW-1:0]    cur_trace_pc, cur_blk_pc;

  always_comb begin
    blk_inc      = (blk_cnt == CNT_MAX) ? CNT_MAX : blk_cnt + 1'b1;
    sum          = {1'b0, done_cnt} + {1'b0, blk_inc};
    fresh        = (done_cnt == '0) && (blk_cnt == '0);
    cur_trace_pc = fresh ? addr : trace_pc;
    cur_blk_pc   = (blk_cnt == '0) ? addr : blk_pc;

    done_nx     = done_cnt;
    blk_nx      = blk_cnt;
    bb_nx       = bb_cnt;
    trace_pc_nx = trace_pc;
    blk_pc_nx   = blk_pc;

    emit    = 1'b0;
    e_start = cur_trace_pc;
    e_uops  = sum[CNT_W-1:0];
    e_bbs   = bb_cnt + 1'b1;
    e_rsn   = term_rsn;
    e_noopt = 1'b0;

    if (take) begin
      if (bb_end) begin
        done_nx = '0;
        blk_nx  = '0;
        bb_nx   = '0;
        if ((done_cnt == '0) && ({1'b0, blk_inc} > CAP_X)) begin
          emit    = 1'b1;
          e_uops  = blk_inc;
          e_bbs   = CNT_W'(1);
          e_rsn   = END_CAPACITY;
          e_noopt = 1'b1;
        end else if (term) begin
          emit = 1'b1;
        end else if (sum == CAP_X) begin
          emit  = 1'b1;
          e_rsn = END_CAPACITY;
        end else begin
          done_nx     = sum[CNT_W-1:0];
          bb_nx       = bb_cnt + 1'b1;
          trace_pc_nx = cur_trace_pc;
        end
      end else begin
        blk_nx    = blk_inc;
        blk_pc_nx = cur_blk_pc;
        if ((done_cnt != '0) && (sum == CAP_X)) begin
          // open block cannot fit: close the trace before it
          emit        = 1'b1;
          e_uops      = done_cnt;
          e_bbs       = bb_cnt;
          e_rsn       = END_CAPACITY;
          done_nx     = '0;
          bb_nx       = '0;
          trace_pc_nx = cur_blk_pc;
        end else begin
          trace_pc_nx = cur_trace_pc;
        end
      end
    end

    if (flush) begin
      emit    = 1'b0;
      done_nx = '0;
      blk_nx  = '0;
      bb_nx   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_cnt <= '0;
      blk_cnt  <= '0;
      bb_cnt   <= '0;
      trace_pc <= '0;
      blk_pc   <= '0;
    end else begin
      done_cnt <= done_nx;
      blk_cnt  <= blk_nx;
      bb_cnt   <= bb_nx;
      trace_pc <= trace_pc_nx;
      blk_pc   <= blk_pc_nx;
    end
  end

endmodule

// File: rtl/ts_out_reg.sv
module ts_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        q     <= d;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/trace_selector.sv
module trace_selector
  import trace_sel_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CAP   = 64,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  input  logic             in_bb_end,
  input  logic [2:0]       in_cti,
  input  logic             in_taken,
  input  logic [AW-1:0]    in_target,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_start,
  output logic [CNT_W-1:0] out_uops,
  output logic [CNT_W-1:0] out_bbs,
  output logic [2:0]       out_reason,
  output logic             out_noopt
);

  localparam int DW = AW + 2 * CNT_W + 4;

  logic             take;
  logic             term;
  end_reason_e      term_rsn;
  logic             emit;
  logic [AW-1:0]    e_start;
  logic [CNT_W-1:0] e_uops, e_bbs;
  end_reason_e      e_rsn;
  logic             e_noopt;
  logic [DW-1:0]    desc_d, desc_q;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  ts_classify #(.AW(AW)) u_classify (
    .cti      (cti_e'(in_cti)),
    .taken    (in_taken),
    .addr     (in_addr),
    .target   (in_target),
    .term     (term),
    .term_rsn (term_rsn)
  );

  ts_accum #(.AW(AW), .CAP(CAP), .CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .take     (take),
    .addr     (in_addr),
    .bb_end   (in_bb_end),
    .term     (term),
    .term_rsn (term_rsn),
    .emit     (emit),
    .e_start  (e_start),
    .e_uops   (e_uops),
    .e_bbs    (e_bbs),
    .e_rsn    (e_rsn),
    .e_noopt  (e_noopt)
  );

  assign desc_d = {e_start, e_uops, e_bbs, e_rsn, e_noopt};

  ts_out_reg #(.DW(DW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (emit),
    .d     (desc_d),
    .ready (out_ready),
    .valid (out_valid),
    .q     (desc_q)
  );

  assign {out_start, out_uops, out_bbs, out_reason, out_noopt} = desc_q;

endmodule

// File: rtl/trace_selector_chk.sv
module trace_selector_chk #(
  parameter int AW    = 32,
  parameter int CAP   = 64,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_start,
  input logic [CNT_W-1:0] out_uops,
  input logic [CNT_W-1:0] out_bbs,
  input logic [2:0]       out_reason,
  input logic             out_noopt
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start) && $stable(out_uops)
                                   && $stable(out_bbs) && $stable(out_reason) && $stable(out_noopt)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_noopt) |-> (out_uops != '0) && (int'(out_uops) <= CAP) && (out_reason <= 3'd3));

  assert_oversize_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_noopt) |-> (out_reason == 3'd0) && (out_bbs == CNT_W'(1)) && (int'(out_uops) > CAP));

  assert_whole_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bbs != '0) && (out_bbs <= out_uops));

endmodule

bind trace_selector trace_selector_chk #(.AW(AW), .CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_start  (out_start),
  .out_uops   (out_uops),
  .out_bbs    (out_bbs),
  .out_reason (out_reason),
  .out_noopt  (out_noopt)
);

// File: tb/test_trace_selector.sv
`timescale 1ns/1ps
module test_trace_selector;

  localparam int AW   = 16;
  localparam int CAP  = 8;
  localparam int CW   = $clog2(CAP + 1);
  localparam int CMAX = (1 << CW) - 1;
  localparam int DW   = AW + 2 * CW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic          in_bb_end = 1'b0;
  logic [2:0]    in_cti = 3'd0;
  logic          in_taken = 1'b0;
  logic [AW-1:0] in_target = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_start;
  logic [CW-1:0] out_uops, out_bbs;
  logic [2:0]    out_reason;
  logic          out_noopt;

  always #5 clk = ~clk;

  trace_selector #(.AW(AW), .CAP(CAP)) i_trace_selector (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_bb_end(in_bb_end), .in_cti(in_cti), .in_taken(in_taken), .in_target(in_target),
    .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
    .out_uops(out_uops), .out_bbs(out_bbs), .out_reason(out_reason), .out_noopt(out_noopt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  string         tag_force = "";

  int            m_c = 0;
  int            m_bbs = 0;
  logic [AW-1:0] m_start = '0;
  logic [AW-1:0] pc = 16'h0100;
  logic [15:0]   rnd = 16'hACE1;
  logic [15:0]   rrdy = 16'h5A5A;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    logic [15:0] x;
    x = v;
    x = x ^ (x << 7);
    x = x ^ (x >> 9);
    x = x ^ (x << 8);
    return x;
  endfunction

  task automatic push(input logic [AW-1:0] st, input int u, input int b,
                      input int rsn, input bit noopt);
    string t;
    if (tag_force != "") t = tag_force;
    else if (noopt) t = "R8";
    else if (rsn == 1) t = "R3";
    else if (rsn == 2) t = "R4";
    else if (rsn == 3) t = "R5";
    else t = "R7";
    exp_q.push_back({st, CW'(u), CW'(b), 3'(rsn), noopt});
    tag_q.push_back(t);
  endtask

  // expected traces, built per block from the requirements
  task automatic model_block(input logic [AW-1:0] a, input int len,
                             input bit term, input int rsn);
    if (m_c > 0 && m_c + len > CAP) begin
      push(m_start, m_c, m_bbs, 0, 1'b0);
      m_c = 0; m_bbs = 0;
    end
    if (m_c == 0) m_start = a;
    if (m_c == 0 && len > CAP) begin
      push(a, (len > CMAX) ? CMAX : len, 1, 0, 1'b1);
    end else begin
      m_c += len;
      m_bbs++;
      if (term) begin
        push(m_start, m_c, m_bbs, rsn, 1'b0);
        m_c = 0; m_bbs = 0;
      end else if (m_c == CAP) begin
        push(m_start, m_c, m_bbs, 0, 1'b0);
        m_c = 0; m_bbs = 0;
      end
    end
  endtask

  task automatic model_partial_flush(input int k);
    if (m_c > 0 && m_c + k >= CAP) push(m_start, m_c, m_bbs, 0, 1'b0);
    m_c = 0; m_bbs = 0;
  endtask

  task automatic send_uop(input logic [AW-1:0] a, input bit last, input logic [2:0] cti,
                          input bit tk, input logic [AW-1:0] tgt);
    in_valid = 1'b1; in_addr = a; in_bb_end = last;
    in_cti = cti; in_taken = tk; in_target = tgt;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9", "in_ready during flush", 64'(in_ready), 64'd0);
    @(negedge clk);
    flush = 1'b0;
  endtask

  // kinds: 0 none, 1 fwd taken, 2 not-taken back, 3 back taken, 4 taken to self,
  // 5 indirect, 6 call, 7 return, 8 exception
  task automatic send_block(input int len, input int kind, input int cut);
    logic [AW-1:0] a, last, tgt;
    logic [2:0]    cti;
    bit            tk, term;
    int            rsn;
    a = pc; last = pc + AW'(len - 1);
    tgt = last - 16'd2; tk = 1'b0; term = 1'b0; rsn = 0; cti = 3'd0;
    case (kind)
      1: begin cti = 3'd1; tk = 1'b1; tgt = last + 16'd5; end
      2: begin cti = 3'd1; tk = 1'b0; end
      3: begin cti = 3'd1; tk = 1'b1; term = 1'b1; rsn = 3; end
      4: begin cti = 3'd1; tk = 1'b1; tgt = last; term = 1'b1; rsn = 3; end
      5: begin cti = 3'd2; term = 1'b1; rsn = 1; end
      6: begin cti = 3'd3; tk = 1'b1; tgt = last + 16'd40; end
      7: begin cti = 3'd4; tk = 1'b1; end
      8: begin cti = 3'd5; term = 1'b1; rsn = 2; end
      default: cti = 3'd0;
    endcase
    if (cut > 0 && cut < len) begin
      model_partial_flush(cut);
      for (int i = 0; i < cut; i++) send_uop(a + AW'(i), 1'b0, 3'd0, 1'b0, '0);
      do_flush();
    end else begin
      model_block(a, len, term, rsn);
      for (int i = 0; i < len; i++) begin
        if (i == len - 1) send_uop(a + AW'(i), 1'b1, cti, tk, tgt);
        else              send_uop(a + AW'(i), 1'b0, 3'd0, 1'b0, '0);
      end
    end
    pc = pc + AW'(len);
  endtask

  // output monitor: random back-pressure, hold check, descriptor compare
  logic [DW-1:0] held;
  bit            hold_chk = 1'b0;
  always @(negedge clk) begin
    if (rst_n && running) begin
      rrdy = step(rrdy);
      out_ready = (rrdy[1:0] != 2'b00);
      if (hold_chk)
        chk(out_valid && ({out_start, out_uops, out_bbs, out_reason, out_noopt} == held),
            "R10", "descriptor held under back-pressure",
            64'({out_start, out_uops, out_bbs, out_reason, out_noopt}), 64'(held));
      hold_chk = out_valid && !out_ready;
      held = {out_start, out_uops, out_bbs, out_reason, out_noopt};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected descriptor",
              64'({out_start, out_uops, out_bbs, out_reason, out_noopt}), 64'd0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_start, out_uops, out_bbs, out_reason, out_noopt} == e, t,
              "descriptor {start,uops,bbs,reason,noopt}",
              64'({out_start, out_uops, out_bbs, out_reason, out_noopt}), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    running = 1'b1;

    // R6: call and return blocks do not close the trace
    tag_force = "R6";
    send_block(2, 6, 0);
    send_block(2, 7, 0);
    send_block(1, 8, 0);
    // R8: oversized block, count saturates
    tag_force = "R8";
    send_block(CAP + 12, 0, 0);
    // R9: flush drops partial trace; next trace starts fresh
    tag_force = "R9";
    send_block(3, 0, 0);
    do_flush();
    m_c = 0; m_bbs = 0;
    send_block(2, 5, 0);
    tag_force = "";

    // sweep: every length against every kind
    for (int len = 1; len <= CAP + 3; len++)
      for (int k = 0; k <= 8; k++)
        send_block(len, k, 0);

    // pseudo-random mix with occasional flush
    for (int n = 0; n < 500; n++) begin
      int len, k, cut;
      rnd = step(rnd);
      len = 1 + int'(rnd[3:0]) % (CAP + 3);
      k = int'(rnd[9:6]) % 9;
      cut = (rnd[15:12] == 4'hF) ? int'(rnd[11:10]) : 0;
      send_block(len, k, cut);
      if (rnd[15:11] == 5'h00) do_flush();
      if (rnd[15:11] == 5'h00) begin m_c = 0; m_bbs = 0; end
    end

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all expected descriptors seen", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule